// File: doc/BRIEF.md
# Outbound Address Decoder with Subtractive Legacy Port

This block sits below an upstream coherent link and picks exactly one downstream target for every outbound request. It first checks the request's node identifier against the identifiers assigned to this hub. A request whose identifier is not one of them is refused and flagged as an error. A request that passes the check is routed only by its address. The address is compared at the same time against every positive-decode window: memory, I/O and interrupt-controller windows for each PCIe-style port, one memory window for the configuration-register target and one for the performance-monitor target.

A request that hits no window, and every message or special cycle, goes to the legacy port. That port always acts as the subtractive port. Its enable bits, its bridge windows and its graphics-range enable are ignored for routing. If software programs overlapping windows, the lowest-numbered target wins and a multi-hit flag is raised so the error can be seen. The result is registered and appears with a valid strobe one cycle after the request.

Top module: `obd_router`

## Requirements
- R1: When a valid request carries a node ID equal to none of the assigned IDs in `cfg_node_ids`, the registered result has `out_err`=1, `out_sel` all zero and `out_multi`=0.
- R2: Every window is a base/limit pair that includes both ends. A window whose limit is below its base matches no address.
- R3: A memory request hits port i's memory window only while `port_mse[i]`=1. An I/O request (`req_is_io`=1) hits port i's I/O window only while `port_iose[i]`=1.
- R4: A memory request inside port i's interrupt-controller window hits port i regardless of `port_mse[i]`. I/O requests never use that window.
- R5: A memory request inside the configuration-register window selects `out_sel` bit NPORTS. One inside the performance-monitor window selects bit NPORTS+1. I/O requests hit neither.
- R6: A request that hits no window selects the legacy port, `out_sel` bit NPORTS+2, whatever `leg_mse` and `leg_iose` hold.
- R7: A message request (`req_is_msg`=1) with a valid node ID selects the legacy port, whatever its address, and `out_multi` stays 0.
- R8: The legacy port's memory, I/O and interrupt-controller windows and its graphics enable (memory range 0xA0000 to 0xBFFFF) never count as a positive hit. An address inside them that also hits port i goes to port i with `out_multi`=0.
- R9: When two or more windows hit, the lowest-numbered `out_sel` bit is chosen and `out_multi`=1. With one hit or none, `out_multi`=0.
- R10: `out_valid` equals `req_valid` of the previous cycle. The result belongs to that request. When `out_valid`=0, `out_sel`, `out_err` and `out_multi` are all 0, which is also their reset value.
- R11: Every result with `out_valid`=1 and `out_err`=0 has exactly one `out_sel` bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_nid | input | NIDW | Node ID carried by the request |
| req_addr | input | AW | Request address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_is_msg | input | 1 | Message or special cycle for the legacy controller |
| cfg_node_ids | input | NUM_NID*NIDW | Node IDs assigned to this hub, entry k at [k*NIDW +: NIDW] |
| port_mem_base | input | NPORTS*AW | Per-port memory window base, port i at [i*AW +: AW] |
| port_mem_limit | input | NPORTS*AW | Per-port memory window limit |
| port_io_base | input | NPORTS*AW | Per-port I/O window base |
| port_io_limit | input | NPORTS*AW | Per-port I/O window limit |
| port_apic_base | input | NPORTS*AW | Per-port interrupt-controller window base |
| port_apic_limit | input | NPORTS*AW | Per-port interrupt-controller window limit |
| port_mse | input | NPORTS | Per-port memory space enable |
| port_iose | input | NPORTS | Per-port I/O space enable |
| csr_base | input | AW | Configuration-register target base |
| csr_limit | input | AW | Configuration-register target limit |
| pmon_base | input | AW | Performance-monitor target base |
| pmon_limit | input | AW | Performance-monitor target limit |
| leg_mem_base | input | AW | Legacy port memory window base (ignored) |
| leg_mem_limit | input | AW | Legacy port memory window limit (ignored) |
| leg_io_base | input | AW | Legacy port I/O window base (ignored) |
| leg_io_limit | input | AW | Legacy port I/O window limit (ignored) |
| leg_apic_base | input | AW | Legacy port interrupt-controller base (ignored) |
| leg_apic_limit | input | AW | Legacy port interrupt-controller limit (ignored) |
| leg_vga_en | input | 1 | Legacy port graphics-range enable (ignored) |
| leg_mse | input | 1 | Legacy port memory enable (ignored) |
| leg_iose | input | 1 | Legacy port I/O enable (ignored) |
| out_valid | output | 1 | Result strobe |
| out_sel | output | NPORTS+3 | One-hot target: ports 0..NPORTS-1, config, perf-mon, legacy |
| out_err | output | 1 | Node ID refused |
| out_multi | output | 1 | More than one positive window hit |

## Verification
The decision is made by combinational logic feeding one register stage, so select, error and multi-hit are all due exactly one clock edge after the cycle that carried `req_valid`. The bench drives a request just after a falling edge and holds all inputs steady through the next rising edge. It computes the expected result from those held inputs, then compares at the following falling edge, once the register has settled. Idle cycles are checked the same way against an all-zero result. The checker's properties use `|=>` to express the same one-edge delay.

// File: rtl/obd_pkg.sv
package obd_pkg;

  localparam int unsigned WIN_W = 64;

  // Inclusive window test; a limit below the base can never satisfy both sides.
  function automatic logic win_hit(input logic [WIN_W-1:0] a,
                                   input logic [WIN_W-1:0] base,
                                   input logic [WIN_W-1:0] limit);
    return (limit >= base) && (a >= base) && (a <= limit);
  endfunction

  // Fixed graphics memory range that a bridge enable would claim.
  localparam logic [WIN_W-1:0] VGA_LO = 64'h0000_0000_000A_0000;
  localparam logic [WIN_W-1:0] VGA_HI = 64'h0000_0000_000B_FFFF;

  typedef struct packed {
    logic err;
    logic multi;
  } dec_flags_t;

endpackage

// File: rtl/obd_nid_match.sv
module obd_nid_match #(
  parameter int unsigned NIDW    = 5,
  parameter int unsigned NUM_NID = 2
) (
  input  logic [NIDW-1:0]         req_nid,
  input  logic [NUM_NID*NIDW-1:0] cfg_node_ids,
  output logic                    nid_ok
);
  logic [NUM_NID-1:0] eq;

  for (genvar k = 0; k < NUM_NID; k++) begin : g_cmp
    assign eq[k] = (req_nid == cfg_node_ids[k*NIDW +: NIDW]);
  end

  assign nid_ok = |eq;
endmodule

// File: rtl/obd_port_match.sv
module obd_port_match #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic          is_io,
  input  logic [AW-1:0] mem_base,
  input  logic [AW-1:0] mem_limit,
  input  logic [AW-1:0] io_base,
  input  logic [AW-1:0] io_limit,
  input  logic [AW-1:0] apic_base,
  input  logic [AW-1:0] apic_limit,
  input  logic          mse,
  input  logic          iose,
  output logic          hit
);
  import obd_pkg::*;

  logic mem_win, io_win, apic_win;

  assign mem_win  = win_hit(WIN_W'(addr), WIN_W'(mem_base),  WIN_W'(mem_limit));
  assign io_win   = win_hit(WIN_W'(addr), WIN_W'(io_base),   WIN_W'(io_limit));
  assign apic_win = win_hit(WIN_W'(addr), WIN_W'(apic_base), WIN_W'(apic_limit));

  // The interrupt-controller window bypasses the memory enable.
  assign hit = is_io ? (io_win & iose) : ((mem_win & mse) | apic_win);
endmodule

// File: rtl/obd_mem_match.sv
module obd_mem_match #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic          is_io,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic          hit
);
  import obd_pkg::*;

  assign hit = !is_io && win_hit(WIN_W'(addr), WIN_W'(base), WIN_W'(limit));
endmodule

// File: rtl/obd_legacy_match.sv
module obd_legacy_match #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic          is_io,
  input  logic [AW-1:0] mem_base,
  input  logic [AW-1:0] mem_limit,
  input  logic [AW-1:0] io_base,
  input  logic [AW-1:0] io_limit,
  input  logic [AW-1:0] apic_base,
  input  logic [AW-1:0] apic_limit,
  input  logic          vga_en,
  input  logic          mse,
  input  logic          iose,
  output logic          raw_hit
);
  import obd_pkg::*;

  logic mem_win, io_win, apic_win, vga_win;

  assign mem_win  = win_hit(WIN_W'(addr), WIN_W'(mem_base),  WIN_W'(mem_limit));
  assign io_win   = win_hit(WIN_W'(addr), WIN_W'(io_base),   WIN_W'(io_limit));
  assign apic_win = win_hit(WIN_W'(addr), WIN_W'(apic_base), WIN_W'(apic_limit));
  assign vga_win  = win_hit(WIN_W'(addr), VGA_LO, VGA_HI);

  // What the legacy bridge would claim if it were a positive target.
  assign raw_hit = is_io ? (io_win & iose)
                         : (((mem_win | (vga_win & vga_en)) & mse) | apic_win);
endmodule

// File: rtl/obd_select.sv
module obd_select #(
  parameter int unsigned NT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_is_msg,
  input  logic          nid_ok,
  input  logic [NT-1:0] pos_hits,
  output logic          out_valid,
  output logic [NT-1:0] out_sel,
  output logic          out_err,
  output logic          out_multi
);
  import obd_pkg::*;

  localparam int unsigned LEG = NT - 1;
  localparam logic [NT-1:0] LEG_ONEHOT = {1'b1, {(NT-1){1'b0}}};

  logic [NT-1:0] first_hit;
  logic          any_hit;
  logic          many_hit;
  logic [NT-1:0] next_sel;
  dec_flags_t    next_flags;

  // Lowest-numbered hit wins.
  always_comb begin
    logic found;
    found     = 1'b0;
    first_hit = '0;
    for (int i = 0; i < NT; i++) begin
      if (pos_hits[i] && !found) begin
        first_hit[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  assign any_hit  = |pos_hits;
  assign many_hit = ($countones(pos_hits) > 1);

  always_comb begin
    next_sel         = '0;
    next_flags.err   = 1'b0;
    next_flags.multi = 1'b0;
    if (!nid_ok) begin
      next_flags.err = 1'b1;
    end else if (req_is_msg) begin
      next_sel = LEG_ONEHOT;
    end else begin
      next_sel         = any_hit ? first_hit : LEG_ONEHOT;
      next_flags.multi = many_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sel   <= '0;
      out_err   <= 1'b0;
      out_multi <= 1'b0;
    end else begin
      out_valid <= req_valid;
      out_sel   <= req_valid ? next_sel : '0;
      out_err   <= req_valid & next_flags.err;
      out_multi <= req_valid & next_flags.multi;
    end
  end

  initial begin
    if (LEG != NT - 1) $error("legacy index misplaced");
  end
endmodule

// File: rtl/obd_router.sv
module obd_router #(
  parameter int unsigned NPORTS             = 4,
  parameter int unsigned AW                 = 32,
  parameter int unsigned NIDW               = 5,
  parameter int unsigned NUM_NID            = 2,
  parameter bit          LEGACY_SUBTRACTIVE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [NIDW-1:0]         req_nid,
  input  logic [AW-1:0]           req_addr,
  input  logic                    req_is_io,
  input  logic                    req_is_msg,
  input  logic [NUM_NID*NIDW-1:0] cfg_node_ids,
  input  logic [NPORTS*AW-1:0]    port_mem_base,
  input  logic [NPORTS*AW-1:0]    port_mem_limit,
  input  logic [NPORTS*AW-1:0]    port_io_base,
  input  logic [NPORTS*AW-1:0]    port_io_limit,
  input  logic [NPORTS*AW-1:0]    port_apic_base,
  input  logic [NPORTS*AW-1:0]    port_apic_limit,
  input  logic [NPORTS-1:0]       port_mse,
  input  logic [NPORTS-1:0]       port_iose,
  input  logic [AW-1:0]           csr_base,
  input  logic [AW-1:0]           csr_limit,
  input  logic [AW-1:0]           pmon_base,
  input  logic [AW-1:0]           pmon_limit,
  input  logic [AW-1:0]           leg_mem_base,
  input  logic [AW-1:0]           leg_mem_limit,
  input  logic [AW-1:0]           leg_io_base,
  input  logic [AW-1:0]           leg_io_limit,
  input  logic [AW-1:0]           leg_apic_base,
  input  logic [AW-1:0]           leg_apic_limit,
  input  logic                    leg_vga_en,
  input  logic                    leg_mse,
  input  logic                    leg_iose,
  output logic                    out_valid,
  output logic [NPORTS+2:0]       out_sel,
  output logic                    out_err,
  output logic                    out_multi
);
  localparam int unsigned NT       = NPORTS + 3;
  localparam int unsigned CSR_IDX  = NPORTS;
  localparam int unsigned PMON_IDX = NPORTS + 1;
  localparam int unsigned LEG_IDX  = NPORTS + 2;

  // Named internal events used by the bound checker.
  logic          nid_ok;
  logic [NT-1:0] pos_hits;
  logic          leg_raw_hit;

  obd_nid_match #(.NIDW(NIDW), .NUM_NID(NUM_NID)) u_nid (
    .req_nid      (req_nid),
    .cfg_node_ids (cfg_node_ids),
    .nid_ok       (nid_ok)
  );

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    obd_port_match #(.AW(AW)) u_pm (
      .addr       (req_addr),
      .is_io      (req_is_io),
      .mem_base   (port_mem_base[i*AW +: AW]),
      .mem_limit  (port_mem_limit[i*AW +: AW]),
      .io_base    (port_io_base[i*AW +: AW]),
      .io_limit   (port_io_limit[i*AW +: AW]),
      .apic_base  (port_apic_base[i*AW +: AW]),
      .apic_limit (port_apic_limit[i*AW +: AW]),
      .mse        (port_mse[i]),
      .iose       (port_iose[i]),
      .hit        (pos_hits[i])
    );
  end

  obd_mem_match #(.AW(AW)) u_csr (
    .addr  (req_addr),
    .is_io (req_is_io),
    .base  (csr_base),
    .limit (csr_limit),
    .hit   (pos_hits[CSR_IDX])
  );

  obd_mem_match #(.AW(AW)) u_pmon (
    .addr  (req_addr),
    .is_io (req_is_io),
    .base  (pmon_base),
    .limit (pmon_limit),
    .hit   (pos_hits[PMON_IDX])
  );

  obd_legacy_match #(.AW(AW)) u_leg (
    .addr       (req_addr),
    .is_io      (req_is_io),
    .mem_base   (leg_mem_base),
    .mem_limit  (leg_mem_limit),
    .io_base    (leg_io_base),
    .io_limit   (leg_io_limit),
    .apic_base  (leg_apic_base),
    .apic_limit (leg_apic_limit),
    .vga_en     (leg_vga_en),
    .mse        (leg_mse),
    .iose       (leg_iose),
    .raw_hit    (leg_raw_hit)
  );

  // As subtractive port the legacy bridge claims nothing positively.
  if (LEGACY_SUBTRACTIVE) begin : g_sub
    assign pos_hits[LEG_IDX] = 1'b0 & leg_raw_hit;
  end else begin : g_pos
    assign pos_hits[LEG_IDX] = leg_raw_hit;
  end

  obd_select #(.NT(NT)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_is_msg (req_is_msg),
    .nid_ok     (nid_ok),
    .pos_hits   (pos_hits),
    .out_valid  (out_valid),
    .out_sel    (out_sel),
    .out_err    (out_err),
    .out_multi  (out_multi)
  );
endmodule

// File: rtl/obd_router_chk.sv
module obd_router_chk #(
  parameter int unsigned NPORTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_is_msg,
  input logic              nid_ok,
  input logic [NPORTS+2:0] pos_hits,
  input logic              leg_raw_hit,
  input logic              out_valid,
  input logic [NPORTS+2:0] out_sel,
  input logic              out_err,
  input logic              out_multi
);
  localparam int unsigned NT = NPORTS + 3;
  localparam logic [NT-1:0] LEG_ONEHOT = {1'b1, {(NT-1){1'b0}}};

  assert_nid_refused_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !nid_ok) |=> (out_err && out_sel == '0 && !out_multi));

  assert_err_no_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_sel == '0));

  assert_subtractive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && nid_ok && !req_is_msg && pos_hits == '0) |=> (out_sel == LEG_ONEHOT));

  assert_msg_legacy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && nid_ok && req_is_msg) |=> (out_sel == LEG_ONEHOT && !out_multi));

  assert_legacy_not_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && leg_raw_hit) |-> !pos_hits[NT-1]);

  assert_multi_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && nid_ok && !req_is_msg && $countones(pos_hits) > 1) |=> out_multi);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && out_sel == '0 && !out_err && !out_multi));

  assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> ($countones(out_sel) == 1));
endmodule

bind obd_router obd_router_chk #(.NPORTS(NPORTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_is_msg  (req_is_msg),
  .nid_ok      (nid_ok),
  .pos_hits    (pos_hits),
  .leg_raw_hit (leg_raw_hit),
  .out_valid   (out_valid),
  .out_sel     (out_sel),
  .out_err     (out_err),
  .out_multi   (out_multi)
);

// File: tb/obd_router_test.sv
`timescale 1ns/1ps
module obd_router_test;
  localparam int NP   = 4;
  localparam int AW   = 32;
  localparam int NIDW = 5;
  localparam int NNID = 2;
  localparam int NT   = NP + 3;
  localparam int LEG  = NP + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                 req_valid = 1'b0;
  logic [NIDW-1:0]      req_nid = 5'd3;
  logic [AW-1:0]        req_addr = '0;
  logic                 req_is_io = 1'b0;
  logic                 req_is_msg = 1'b0;
  logic [NNID*NIDW-1:0] cfg_node_ids = {5'd9, 5'd3};
  logic [NP*AW-1:0]     mb, ml, ib, il, ab, al;
  logic [NP-1:0]        mse, iose;
  logic [AW-1:0]        cb, cl, pb, pl, lmb, lml, lib, lil, lab, lal;
  logic                 lvga, lmse, liose;
  logic                 out_valid, out_err, out_multi;
  logic [NT-1:0]        out_sel;

  int tests = 0;
  int fails = 0;

  obd_router #(.NPORTS(NP), .AW(AW), .NIDW(NIDW), .NUM_NID(NNID)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_nid(req_nid),
    .req_addr(req_addr), .req_is_io(req_is_io), .req_is_msg(req_is_msg),
    .cfg_node_ids(cfg_node_ids),
    .port_mem_base(mb), .port_mem_limit(ml), .port_io_base(ib), .port_io_limit(il),
    .port_apic_base(ab), .port_apic_limit(al), .port_mse(mse), .port_iose(iose),
    .csr_base(cb), .csr_limit(cl), .pmon_base(pb), .pmon_limit(pl),
    .leg_mem_base(lmb), .leg_mem_limit(lml), .leg_io_base(lib), .leg_io_limit(lil),
    .leg_apic_base(lab), .leg_apic_limit(lal), .leg_vga_en(lvga),
    .leg_mse(lmse), .leg_iose(liose),
    .out_valid(out_valid), .out_sel(out_sel), .out_err(out_err), .out_multi(out_multi)
  );

  function automatic bit inside_win(logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] l);
    return !(a < b) && !(a > l);
  endfunction

  // Expected routing, built from the requirement text.
  function automatic void predict(output logic [NT-1:0] s, output logic e, output logic m);
    bit known = 0;
    int first = -1;
    int cnt = 0;
    bit h;
    for (int k = 0; k < NNID; k++)
      if (cfg_node_ids[k*NIDW +: NIDW] == req_nid) known = 1;
    s = '0; e = 0; m = 0;
    if (!known) begin e = 1; return; end
    if (req_is_msg) begin s[LEG] = 1'b1; return; end
    for (int idx = 0; idx < NP + 2; idx++) begin
      if (idx < NP) begin
        if (req_is_io) h = iose[idx] && inside_win(req_addr, ib[idx*AW +: AW], il[idx*AW +: AW]);
        else h = (mse[idx] && inside_win(req_addr, mb[idx*AW +: AW], ml[idx*AW +: AW]))
                 || inside_win(req_addr, ab[idx*AW +: AW], al[idx*AW +: AW]);
      end else if (idx == NP) h = !req_is_io && inside_win(req_addr, cb, cl);
      else h = !req_is_io && inside_win(req_addr, pb, pl);
      if (h) begin
        cnt++;
        if (first < 0) first = idx;
      end
    end
    if (first < 0) s[LEG] = 1'b1;
    else s[first] = 1'b1;
    m = (cnt > 1);
  endfunction

  task automatic check(string tag, logic [NT-1:0] es, logic ee, logic em, logic ev);
    tests++;
    if (out_sel !== es || out_err !== ee || out_multi !== em || out_valid !== ev) begin
      fails++;
      $display("FAIL %s: got valid=%b sel=%b err=%b multi=%b, expected valid=%b sel=%b err=%b multi=%b",
               tag, out_valid, out_sel, out_err, out_multi, ev, es, ee, em);
    end
  endtask

  // Drive one request after a falling edge and compare at the next falling edge.
  task automatic send(string tag);
    logic [NT-1:0] es;
    logic ee, em;
    @(negedge clk);
    req_valid = 1'b1;
    predict(es, ee, em);
    @(negedge clk);
    check(tag, es, ee, em, 1'b1);
    if (!ee && $countones(out_sel) != 1) begin
      tests++; fails++;
      $display("FAIL R11: sel=%b not one-hot", out_sel);
    end
    req_valid = 1'b0;
  endtask

  task automatic clear_cfg();
    mb = '0; ml = '0; ib = '0; il = '0; ab = '0; al = '0;
    for (int i = 0; i < NP; i++) begin
      mb[i*AW +: AW] = 1; ib[i*AW +: AW] = 1; ab[i*AW +: AW] = 1;
    end
    mse = '1; iose = '1;
    cb = 1; cl = 0; pb = 1; pl = 0;
    lmb = 1; lml = 0; lib = 1; lil = 0; lab = 1; lal = 0;
    lvga = 0; lmse = 1; liose = 1;
    req_nid = 5'd3; req_is_io = 0; req_is_msg = 0;
  endtask

  function automatic logic [NT-1:0] bit_at(int i);
    logic [NT-1:0] v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [AW-1:0] rnd_base();
    return AW'($urandom_range(0, 32'hF00));
  endfunction

  function automatic logic [AW-1:0] rnd_lim(logic [AW-1:0] b);
    if ($urandom_range(0, 7) == 0 && b > 0) return b - 1;
    return b + AW'($urandom_range(0, 32'h200));
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: got no completion, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h0BD5_1E7A));
    clear_cfg();
    repeat (3) @(negedge clk);
    check("R10 reset state", '0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 idle", '0, 0, 0, 0);

    // R1 unknown node ID
    mb[0 +: AW] = 32'h100; ml[0 +: AW] = 32'h1FF;
    req_addr = 32'h150; req_nid = 5'd4;
    send("R1 bad node id");
    req_nid = 5'd9;
    send("R1 second assigned id accepted");
    req_nid = 5'd3;

    // R2 inclusive ends and inverted window
    req_addr = 32'h100; send("R2 base edge");
    req_addr = 32'h1FF; send("R2 limit edge");
    req_addr = 32'h200; send("R2 past limit");
    mb[AW +: AW] = 32'h300; ml[AW +: AW] = 32'h2FF;
    req_addr = 32'h300; send("R2 limit below base");

    // R3 enables
    mse[0] = 0; req_addr = 32'h150; send("R3 mse clear");
    mse[0] = 1;
    ib[2*AW +: AW] = 32'h40; il[2*AW +: AW] = 32'h4F; req_is_io = 1; req_addr = 32'h44;
    send("R3 io hit");
    iose[2] = 0; send("R3 iose clear");
    iose[2] = 1; req_is_io = 0; send("R3 memory ignores io window");

    // R4 interrupt-controller window bypasses mse
    ab[3*AW +: AW] = 32'hFEC0_0000; al[3*AW +: AW] = 32'hFEC0_0FFF; mse[3] = 0;
    req_addr = 32'hFEC0_0010; send("R4 apic with mse clear");
    req_is_io = 1; send("R4 io skips apic window");
    req_is_io = 0;

    // R5 config and perf-mon targets
    cb = 32'h8000; cl = 32'h8FFF; pb = 32'h9000; pl = 32'h90FF;
    req_addr = 32'h8FFF; send("R5 csr target");
    req_addr = 32'h9000; send("R5 perfmon target");
    req_is_io = 1; send("R5 io misses perfmon");
    req_is_io = 0;

    // R6 subtractive with legacy enables clear
    lmse = 0; liose = 0; req_addr = 32'h5555; send("R6 no hit to legacy");
    req_is_io = 1; send("R6 io no hit to legacy");
    req_is_io = 0;

    // R7 message cycles
    req_is_msg = 1; req_addr = 32'h150; send("R7 message overrides window");
    req_is_msg = 0;

    // R8 legacy windows ignored
    lmse = 1; lmb = 32'h100; lml = 32'h1FF; req_addr = 32'h180; send("R8 legacy mem window");
    lvga = 1; mb[AW +: AW] = 32'hA0000; ml[AW +: AW] = 32'hA0FFF;
    req_addr = 32'hA0800; send("R8 vga enable ignored");
    lab = 32'hA0000; lal = 32'hA0FFF; send("R8 legacy apic ignored");
    req_addr = 32'hB0000; send("R8 vga range stays subtractive");

    // R9 overlap
    mb[2*AW +: AW] = 32'h100; ml[2*AW +: AW] = 32'h1FF;
    req_addr = 32'h1F0; send("R9 overlap ports 0 and 2");
    mse[0] = 0; send("R9 single hit after enable clear");
    mse[0] = 1;

    // R10 back-to-back then idle
    @(negedge clk);
    check("R10 idle after request", '0, 0, 0, 0);

    // Random mix
    for (int it = 0; it < 600; it++) begin
      string tag;
      logic [NT-1:0] es;
      logic ee, em;
      if (it % 8 == 0) begin
        for (int i = 0; i < NP; i++) begin
          mb[i*AW +: AW] = rnd_base(); ml[i*AW +: AW] = rnd_lim(mb[i*AW +: AW]);
          ib[i*AW +: AW] = rnd_base(); il[i*AW +: AW] = rnd_lim(ib[i*AW +: AW]);
          ab[i*AW +: AW] = rnd_base(); al[i*AW +: AW] = AW'(ab[i*AW +: AW] + AW'($urandom_range(0, 32'h20)));
        end
        mse = NP'($urandom); iose = NP'($urandom);
        cb = rnd_base(); cl = rnd_lim(cb); pb = rnd_base(); pl = rnd_lim(pb);
        lmb = rnd_base(); lml = rnd_lim(lmb); lib = rnd_base(); lil = rnd_lim(lib);
        lab = rnd_base(); lal = rnd_lim(lab);
        lvga = 1'($urandom); lmse = 1'($urandom); liose = 1'($urandom);
      end
      req_addr   = AW'($urandom_range(0, 32'hFFF));
      req_is_io  = ($urandom_range(0, 2) == 0);
      req_is_msg = ($urandom_range(0, 9) == 0);
      req_nid    = ($urandom_range(0, 7) == 0) ? NIDW'($urandom) : (($urandom_range(0, 1) == 0) ? 5'd3 : 5'd9);
      predict(es, ee, em);
      if (ee) tag = "R1 random";
      else if (req_is_msg) tag = "R7 random";
      else if (em) tag = "R9 random";
      else if (es[LEG]) tag = "R6 random";
      else tag = "R3 random";
      send(tag);
    end

    finish_run();
  end

  // Keep bench-side references to the subtractive bit positions explicit.
  initial begin
    if (bit_at(LEG) != {1'b1, {(NT-1){1'b0}}}) $display("legacy bit position mismatch");
  end
endmodule